// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a small processor core that finishes every instruction in one clock period. It supports nine operations: word load, word store, add, subtract, AND, OR, signed set-less-than, branch-if-equal and an absolute jump. All of these fit in one 32-bit fixed instruction format. The core holds a program counter with its next-address logic, a register file of 32 entries by 32 bits, an ALU, a sign extender and a decoder in two levels. The first level looks at the opcode and produces the datapath steering bits and a 2-bit operation class. The second level turns that class and the function field into the ALU operation.

An instruction memory and a data memory sit inside the top. Both are word arrays that are read combinationally and written on the rising clock edge. A shared load port fills either array, normally while the core is held in reset. Four debug outputs show the current PC and the register write-back of the instruction in flight, so a program's effect can be watched from the pins.

Top module: `sc_cpu_top`

## Requirements
- R1: While `rst_n` is low the PC reads 0, without waiting for a clock edge. During reset, neither a register write nor a data-memory write takes place. After release, the first instruction fetched is the one at byte address 0.
- R2: The PC is always a multiple of 4. For any instruction other than a taken branch or a jump, the next PC is PC+4.
- R3: Load (opcode 0x23 in bits 31:26) forms the byte address base+offset. The base is the register named by bits 25:21. The offset is bits 15:0, sign-extended. The data word at address bits [7:2] is written to the register named by bits 20:16.
- R4: Store (opcode 0x2B) uses the same address rule as R3. It writes the value of register bits 20:16 into data memory and performs no register write. The stored word survives a reset.
- R5: The register-type group (opcode 0x00) reads registers bits 25:21 and 20:16 and writes register bits 15:11. The function code in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR.
- R6: Function code 0x2A writes 1 when the first operand is less than the second as signed 32-bit values, and writes 0 otherwise.
- R7: Branch-if-equal (opcode 0x04) compares the two registers by subtraction and performs no register write. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2, and backward offsets are allowed. When they differ, the next PC is PC+4.
- R8: Jump (opcode 0x02) sets the next PC to the top 4 bits of PC+4, followed by instruction bits 25:0, followed by two zero bits. It performs no register write.
- R9: Register 0 always reads as zero. A write aimed at it appears on the debug outputs but changes nothing.
- R10: `wb_en_o`, `wb_addr_o` and `wb_data_o` show, within the same cycle, the register write that the current instruction commits at the next rising edge.
- R11: When `ld_we` is high, the word on `ld_data` is written at word index `ld_addr` on the rising edge. `ld_sel` chooses the target array: 0 for instruction memory, 1 for data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| ld_we | input | 1 | Load-port write strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | MEM_AW | Load-port word index |
| ld_data | input | 32 | Load-port data word |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Register write-back enable of the current instruction |
| wb_addr_o | output | 5 | Register write-back destination |
| wb_data_o | output | 32 | Register write-back value |

## Verification
The assertions assume that `rst_n` rises in step with the clock. They also assume that every fetched word uses one of the five supported opcodes and, for the register-type group, one of the five function codes. The next-PC properties further assume that the load port does not rewrite the instruction under execution. The stimulus fills both memories only while reset is held. It runs a program made only of supported encodings and ends in a backward branch to itself, so the PC never leaves the loaded words.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     reg_we;
    logic     src_imm;
    logic     mem_we;
    logic     wb_mem;
    logic     is_branch;
    logic     is_jump;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl     = '0;
    ctrl.cls = CLS_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.cls    = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.cls       = CLS_SUB;
      end
      OPC_JUMP: ctrl.is_jump = 1'b1;
      default: ctrl = ctrl;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  alu_cls_e   cls,
  input  logic [5:0] funct,
  output alu_op_e    op
);
  always_comb begin
    op = ALU_ADD;
    case (cls)
      CLS_SUB:   op = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;
        endcase
      end
      default:   op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: y = ~(a | b);
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int NREG = 1 << AW;

  // entry 0 is not stored: it is hard-wired to zero
  logic [W-1:0] bank [1:NREG-1];
  logic         wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) bank[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : bank[ra1];
  assign rd2 = (ra2 == '0) ? '0 : bank[ra2];
endmodule

// File: rtl/sc_cpu_top.sv
module sc_cpu_top
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic              ld_sel,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   pc_o,
  output logic              wb_en_o,
  output logic [RAW-1:0]    wb_addr_o,
  output logic [XLEN-1:0]   wb_data_o
);
  localparam int WORDS = 1 << MEM_AW;

  logic [XLEN-1:0] imem [WORDS];
  logic [XLEN-1:0] dmem [WORDS];

  logic [XLEN-1:0] pc_q, pc_d, pc4, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, sext, rs_val, rt_val, alu_b, alu_y, dmem_q, wb_data;
  logic [RAW-1:0]  wb_dest;
  logic            alu_zero, rf_we, dm_we, im_ld, dm_ld;
  ctrl_t           ctrl;
  alu_op_e         alu_op;

  // fetch and field extraction
  assign instr = imem[pc_q[MEM_AW+1:2]];
  assign sext  = {{16{instr[15]}}, instr[15:0]};

  sc_main_dec u_mdec (.opcode(instr[31:26]), .ctrl(ctrl));
  sc_alu_dec  u_adec (.cls(ctrl.cls), .funct(instr[5:0]), .op(alu_op));

  sc_regfile #(.W(XLEN), .AW(RAW)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .waddr(wb_dest),
    .wdata(wb_data),
    .ra1  (instr[25:21]),
    .ra2  (instr[20:16]),
    .rd1  (rs_val),
    .rd2  (rt_val)
  );

  assign alu_b = ctrl.src_imm ? sext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a   (rs_val),
    .b   (alu_b),
    .op  (alu_op),
    .y   (alu_y),
    .zero(alu_zero)
  );

  // data memory and write-back
  assign dmem_q  = dmem[alu_y[MEM_AW+1:2]];
  assign wb_data = ctrl.wb_mem ? dmem_q : alu_y;
  assign wb_dest = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we   = ctrl.reg_we && rst_n;
  assign dm_we   = ctrl.mem_we && rst_n;
  assign im_ld   = ld_we && !ld_sel;
  assign dm_ld   = ld_we && ld_sel;

  always_ff @(posedge clk) begin
    if (im_ld) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (dm_ld)      dmem[ld_addr] <= ld_data;
    else if (dm_we) dmem[alu_y[MEM_AW+1:2]] <= rt_val;
  end

  // next-PC selection
  assign pc4     = pc_q + 32'd4;
  assign br_tgt  = pc4 + {sext[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.is_jump)                    pc_d = jmp_tgt;
    else if (ctrl.is_branch && alu_zero) pc_d = br_tgt;
    else                                 pc_d = pc4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = rf_we;
  assign wb_addr_o = wb_dest;
  assign wb_data_o = wb_data;
endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        wb_en
);
  logic [5:0]  opc;
  logic [31:0] seq_pc, tk_pc, jp_pc;

  assign opc    = instr[31:26];
  assign seq_pc = pc + 32'd4;
  assign tk_pc  = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jp_pc  = {seq_pc[31:28], instr[25:0], 2'b00};

  AST_RESET_PC_ZERO: assert property (@(posedge clk) !rst_n |-> pc == 32'd0); // R1
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) pc[1:0] == 2'b00); // R2
  AST_SEQ_NEXT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OPC_BEQ && opc != OPC_JUMP) |=> pc == $past(seq_pc)); // R2
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BEQ && rs_val == rt_val) |=> pc == $past(tk_pc)); // R7
  AST_BEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BEQ && rs_val != rt_val) |=> pc == $past(seq_pc)); // R7
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    opc == OPC_JUMP |=> pc == $past(jp_pc)); // R8
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    opc == OPC_STORE |-> !wb_en); // R4
  AST_BRANCH_JUMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BEQ || opc == OPC_JUMP) |-> !wb_en); // R7
  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    instr[25:21] == 5'd0 |-> rs_val == 32'd0); // R9
endmodule

bind sc_cpu_top sc_cpu_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .instr (instr),
  .pc    (pc_o),
  .rs_val(rs_val),
  .rt_val(rt_val),
  .wb_en (wb_en_o)
);

// File: tb/sim_sc_cpu_top.sv
module sim_sc_cpu_top;
  logic        clk;
  logic        rst_n;
  logic        ld_we;
  logic        ld_sel;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_o;
  logic        wb_en_o;
  logic [4:0]  wb_addr_o;
  logic [31:0] wb_data_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sc_cpu_top #(.MEM_AW(6)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] r_op(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_op(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] j_op(int tgt);
    return {6'h02, tgt[25:0]};
  endfunction
  function automatic logic [69:0] tr(logic [31:0] p, logic we, int a, logic [31:0] d);
    return {p, we, a[4:0], d};
  endfunction

  localparam logic [31:0] PROG [23] = '{
    i_op(6'h23, 0, 1, 0),       //  0 load r1
    i_op(6'h23, 0, 2, 4),       //  4 load r2
    i_op(6'h23, 0, 3, 8),       //  8 load r3
    r_op(1, 2, 4, 6'h20),       // 12 add
    r_op(1, 2, 5, 6'h22),       // 16 sub
    r_op(3, 2, 6, 6'h24),       // 20 and
    r_op(5, 1, 7, 6'h25),       // 24 or
    r_op(2, 1, 8, 6'h2A),       // 28 slt true
    r_op(1, 2, 9, 6'h2A),       // 32 slt false
    r_op(1, 1, 0, 6'h20),       // 36 write to r0
    i_op(6'h2B, 5, 4, -4),      // 40 store, negative offset
    i_op(6'h23, 5, 10, -4),     // 44 load back
    r_op(0, 1, 11, 6'h20),      // 48 r0 reads zero
    i_op(6'h04, 1, 2, 5),       // 52 beq not taken
    i_op(6'h04, 4, 4, 2),       // 56 beq taken to 68
    r_op(1, 1, 12, 6'h20),      // 60 skipped
    r_op(1, 1, 12, 6'h20),      // 64 skipped
    j_op(20),                   // 68 jump to 80
    r_op(1, 1, 13, 6'h20),      // 72 skipped
    r_op(1, 1, 13, 6'h20),      // 76 skipped
    r_op(0, 1, 13, 6'h22),      // 80 negative result
    r_op(13, 0, 14, 6'h2A),     // 84 slt with negative operand
    i_op(6'h04, 0, 0, -1)       // 88 backward branch to itself
  };

  localparam logic [31:0] DATA [3] = '{32'h0000_0005, 32'hFFFF_FFFD, 32'h0F0F_00FF};

  // each step: pc, wb enable, wb register, wb value (R10 debug view)
  localparam logic [69:0] TRACE [20] = '{
    tr(32'd0,  1'b1, 1,  32'h0000_0005),   // R3
    tr(32'd4,  1'b1, 2,  32'hFFFF_FFFD),   // R3
    tr(32'd8,  1'b1, 3,  32'h0F0F_00FF),   // R3
    tr(32'd12, 1'b1, 4,  32'h0000_0002),   // R5
    tr(32'd16, 1'b1, 5,  32'h0000_0008),   // R5
    tr(32'd20, 1'b1, 6,  32'h0F0F_00FD),   // R5
    tr(32'd24, 1'b1, 7,  32'h0000_000D),   // R5
    tr(32'd28, 1'b1, 8,  32'h0000_0001),   // R6
    tr(32'd32, 1'b1, 9,  32'h0000_0000),   // R6
    tr(32'd36, 1'b1, 0,  32'h0000_000A),   // R9
    tr(32'd40, 1'b0, 0,  32'h0),           // R4
    tr(32'd44, 1'b1, 10, 32'h0000_0002),   // R4
    tr(32'd48, 1'b1, 11, 32'h0000_0005),   // R9
    tr(32'd52, 1'b0, 0,  32'h0),           // R7
    tr(32'd56, 1'b0, 0,  32'h0),           // R7
    tr(32'd68, 1'b0, 0,  32'h0),           // R8
    tr(32'd80, 1'b1, 13, 32'hFFFF_FFFB),   // R5
    tr(32'd84, 1'b1, 14, 32'h0000_0001),   // R6
    tr(32'd88, 1'b0, 0,  32'h0),           // R7
    tr(32'd88, 1'b0, 0,  32'h0)            // R7
  };
  localparam int TREQ [20] = '{3,3,3,5,5,5,5,6,6,9,4,4,9,7,7,8,5,6,7,7};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic sel, input int idx, input logic [31:0] w);
    ld_we   = 1'b1;
    ld_sel  = sel;
    ld_addr = idx[5:0];
    ld_data = w;
    @(negedge clk);
    ld_we   = 1'b0;
  endtask

  initial begin
    rst_n   = 1'b0;
    ld_we   = 1'b0;
    ld_sel  = 1'b0;
    ld_addr = '0;
    ld_data = '0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 no wb in reset", {31'd0, wb_en_o}, 32'd0);

    // R11: fill both arrays through the load port
    for (int i = 0; i < 23; i++) load(1'b0, i, PROG[i]);
    for (int i = 0; i < 3; i++)  load(1'b1, i, DATA[i]);

    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic [69:0] t;
      t = TRACE[i];
      #1;
      chk($sformatf("R%0d step %0d pc", TREQ[i], i), pc_o, t[69:38]);
      chk($sformatf("R%0d step %0d wb_en", TREQ[i], i), {31'd0, wb_en_o}, {31'd0, t[37]});
      if (t[37]) begin
        chk($sformatf("R%0d step %0d wb_addr", TREQ[i], i), {27'd0, wb_addr_o}, {27'd0, t[36:32]});
        chk($sformatf("R%0d step %0d wb_data", TREQ[i], i), wb_data_o, t[31:0]);
      end
      @(negedge clk);
    end

    // R1: asynchronous reset in mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async pc clear", pc_o, 32'd0);
    chk("R1 wb gated in reset", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk);
    // R11: rewrite word 0 of instruction memory during reset
    load(1'b0, 0, r_op(1, 1, 15, 6'h20));
    rst_n = 1'b1;
    #1;
    chk("R11 reloaded instr wb_addr", {27'd0, wb_addr_o}, 32'd15);
    chk("R11 reloaded instr wb_data", wb_data_o, 32'd10);
    @(negedge clk);
    #1;
    chk("R2 pc after restart", pc_o, 32'd4);
    chk("R4 stored word kept over reset", wb_data_o, 32'd2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule